// File: doc/BRIEF.md
# Decimal Floating-Point Multiplier

This block multiplies two decimal floating-point numbers that share one 32-bit word format. Bit 31 holds the sign (1 means negative). Bits 30:24 hold a two-digit decimal exponent: a tens digit in bits 30:28 and a units digit in bits 27:24, for a stored value v from 0 to 79. A stored value of 40 or more means the exponent v-80, so the exponent covers -40 to +39. Bits 23:0 hold six packed-BCD mantissa digits. The top digit, in bits 23:20, carries a weight of 10^0.

A start pulse captures both operands. The block then forms the full twelve-digit product in a double-width BCD accumulator. It works one multiplier digit at a time, lowest digit first. For each digit it adds the multiplicand into the accumulator as many times as that digit's value, then moves the multiplicand one decimal place to the left. After the last digit it shifts the product left until the top digit is non-zero, adjusting the exponent as it goes. It keeps the top six digits and raises done for one cycle. The result stays on the output until the next completion.

Top module: `bcd_fmul`

## Requirements
- R1: The result sign (bit 31) is the XOR of the two operand signs whenever the product is non-zero.
- R2: The result exponent is the sum of the two operand exponents plus the normalisation adjustment. It is taken modulo 80 and encoded as above, with tens digit in bits 30:28, units in bits 27:24, and stored values 40..79 meaning v-80.
- R3: The result mantissa is the product's leading six decimal digits, truncated with no rounding.
- R4: A non-zero result is normalised (bits 23:20 are non-zero). For two normalised operands, a product of ten or more raises the exponent by one.
- R5: If either operand's mantissa (bits 23:0) is zero, the result is the all-zero word, whatever the signs and exponents.
- R6: A start seen while idle begins an operation. Busy is high until the result appears, and done is a single-cycle pulse that coincides with busy being low.
- R7: A start raised while busy is ignored. The running operation completes with its own operands and no extra result is produced.
- R8: The result output holds its value between done pulses.
- R9: Operands with leading zero mantissa digits are accepted. The product is still normalised and the exponent is reduced by one for each leading zero removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiplication with a and b (taken when idle) |
| a | input | 32 | Multiplicand operand word |
| b | input | 32 | Multiplier operand word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | 32 | Product word |

## Verification
The bench builds the block with its default of six mantissa digits, so the operands are the 32-bit words described above. At that width, all-nines operands give the longest accumulation run and reach the truncation of a twelve-digit product. Small exponents placed near 39 and -40 reach the modulo-80 wrap of the exponent. Mantissas with leading zero digits reach the multi-step normalisation, which a pair of normalised inputs never needs.

// File: rtl/bcd_fmul.sv
module bcd_fmul #(
  parameter int DIGITS = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [4*DIGITS+7:0]   a,
  input  logic [4*DIGITS+7:0]   b,
  output logic                  busy,
  output logic                  done,
  output logic [4*DIGITS+7:0]   result
);
  localparam int MW  = 4 * DIGITS;
  localparam int AW  = 2 * MW;
  localparam int OPW = MW + 8;
  localparam int IW  = $clog2(DIGITS + 1);

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_NORM} state_t;

  state_t            st;
  logic [AW-1:0]     mcand, prod;
  logic [MW-1:0]     mplier;
  logic [3:0]        cnt;
  logic [IW-1:0]     idx;
  logic signed [8:0] expo;
  logic              sgn;

  function automatic int exp_dec(input logic [6:0] e);
    int v;
    v = int'(e[6:4]) * 10 + int'(e[3:0]);
    return (v >= 40) ? v - 80 : v;
  endfunction

  function automatic logic [6:0] exp_enc(input int s);
    int v;
    logic [6:0] r;
    v = s;
    if (v < 0) v = v + 80;
    if (v < 0) v = v + 80;
    if (v >= 80) v = v - 80;
    r[6:4] = 3'(v / 10);
    r[3:0] = 4'(v % 10);
    return r;
  endfunction

  function automatic logic [AW-1:0] bcd_add(input logic [AW-1:0] x, input logic [AW-1:0] y);
    logic [AW-1:0] r;
    logic [4:0]    s;
    logic          c;
    c = 1'b0;
    r = '0;
    for (int i = 0; i < AW / 4; i++) begin
      s = {1'b0, x[4*i +: 4]} + {1'b0, y[4*i +: 4]} + {4'b0, c};
      if (s > 5'd9) begin
        s = s + 5'd6;
        c = 1'b1;
      end else begin
        c = 1'b0;
      end
      r[4*i +: 4] = s[3:0];
    end
    return r;
  endfunction

  wire a_zero = (a[MW-1:0] == '0);
  wire b_zero = (b[MW-1:0] == '0);
  wire last_digit = (idx == IW'(DIGITS - 1));
  wire top_zero = (prod[AW-1 -: 4] == 4'd0);

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      result <= '0;
      mcand  <= '0;
      prod   <= '0;
      mplier <= '0;
      cnt    <= '0;
      idx    <= '0;
      expo   <= '0;
      sgn    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (a_zero || b_zero) begin
            result <= '0;
            done   <= 1'b1;
          end else begin
            mcand  <= {{MW{1'b0}}, a[MW-1:0]};
            mplier <= b[MW-1:0];
            cnt    <= b[3:0];
            idx    <= '0;
            prod   <= '0;
            expo   <= 9'(exp_dec(a[OPW-2:MW]) + exp_dec(b[OPW-2:MW]) + 1);
            sgn    <= a[OPW-1] ^ b[OPW-1];
            st     <= S_ACC;
          end
        end
        S_ACC: begin
          if (cnt != 4'd0) begin
            prod <= bcd_add(prod, mcand);
            cnt  <= cnt - 4'd1;
          end else if (last_digit) begin
            st <= S_NORM;
          end else begin
            mcand  <= mcand << 4;
            mplier <= mplier >> 4;
            cnt    <= mplier[7:4];
            idx    <= idx + 1'b1;
          end
        end
        S_NORM: begin
          if (top_zero) begin
            prod <= prod << 4;
            expo <= expo - 9'sd1;
          end else begin
            result <= {sgn, exp_enc(int'(expo)), prod[AW-1 -: MW]};
            done   <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bcd_fmul_chk.sv
module bcd_fmul_chk #(
  parameter int DIGITS = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [4*DIGITS+7:0] a,
  input logic [4*DIGITS+7:0] b,
  input logic                busy,
  input logic                done,
  input logic [4*DIGITS+7:0] result
);
  localparam int MW = 4 * DIGITS;

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy || done));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  p_norm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result[MW-1:0] != '0) |-> (result[MW-1 -: 4] != 4'd0));

  p_zero_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result[MW-1:0] == '0) |-> (result == '0));

  wire unused_ok = ^{a, b};
endmodule

bind bcd_fmul bcd_fmul_chk #(.DIGITS(DIGITS)) u_chk (.*);

// File: tb/bcd_fmul_test.sv
module bcd_fmul_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        busy, done;
  logic [31:0] result;

  int checks = 0;
  int fails = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  bcd_fmul uut (.clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
                .busy(busy), .done(done), .result(result));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic longint bcd2int(input logic [23:0] m);
    longint v = 0;
    for (int i = 5; i >= 0; i--) v = v * 10 + longint'(m[4*i +: 4]);
    return v;
  endfunction

  function automatic logic [23:0] int2bcd(input longint v);
    logic [23:0] m;
    longint t = v;
    for (int i = 0; i < 6; i++) begin
      m[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return m;
  endfunction

  function automatic int edec(input logic [6:0] e);
    int v = int'(e[6:4]) * 10 + int'(e[3:0]);
    return (v >= 40) ? v - 80 : v;
  endfunction

  function automatic logic [6:0] eenc(input int s);
    int v = ((s % 80) + 80) % 80;
    return {3'(v / 10), 4'(v % 10)};
  endfunction

  function automatic longint p10(input int n);
    longint r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

  function automatic logic [31:0] ref_mul(input logic [31:0] x, input logic [31:0] y);
    longint ma = bcd2int(x[23:0]);
    longint mb = bcd2int(y[23:0]);
    longint p, q, m;
    int n = 0;
    if (ma == 0 || mb == 0) return 32'h0;
    p = ma * mb;
    q = p;
    while (q > 0) begin q = q / 10; n++; end
    m = (n > 6) ? p / p10(n - 6) : p * p10(6 - n);
    return {x[31] ^ y[31], eenc(edec(x[30:24]) + edec(y[30:24]) + n - 11), int2bcd(m)};
  endfunction

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected result", result, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(result === e, t, result, e);
      end
    end
  end

  task automatic op(input logic [31:0] x, input logic [31:0] y, input string tag, input bit poke);
    logic [31:0] e;
    e = ref_mul(x, y);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    a = x; b = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (x[23:0] == 0 || y[23:0] == 0) begin
      check(done === 1'b1 && busy === 1'b0, "R6 zero path done", {30'b0, busy, done}, 32'h1);
    end else begin
      check(busy === 1'b1 && done === 1'b0, "R6 busy after start", {30'b0, busy, done}, 32'h2);
      if (poke) begin
        @(negedge clk);
        a = 32'h0_05_123456; b = 32'h0_05_654321; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R7 still busy after ignored start", {31'b0, busy}, 32'h1);
      end
      while (!done) @(negedge clk);
    end
  endtask

  function automatic logic [31:0] fw(input bit s, input logic [6:0] e, input logic [23:0] m);
    return {s, e, m};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(result === 32'h0 && busy === 1'b0 && done === 1'b0, "R6 reset state", result, 32'h0);
    rst_n = 1'b1;
    op(fw(0, 7'h00, 24'h200000), fw(0, 7'h00, 24'h300000), "R3 2x3", 0);
    op(fw(0, 7'h00, 24'h500000), fw(0, 7'h00, 24'h500000), "R4 5x5 carry exponent", 0);
    op(fw(0, 7'h00, 24'h999999), fw(0, 7'h00, 24'h999999), "R3 truncation all nines", 0);
    op(fw(1, 7'h00, 24'h150000), fw(0, 7'h00, 24'h200000), "R1 negative times positive", 0);
    op(fw(1, 7'h02, 24'h123456), fw(1, 7'h77, 24'h789012), "R1 R2 both negative", 0);
    op(fw(0, 7'h39, 24'h200000), fw(0, 7'h01, 24'h300000), "R2 wrap to -40", 0);
    op(fw(0, 7'h40, 24'h400000), fw(0, 7'h79, 24'h300000), "R2 wrap negative", 0);
    op(fw(1, 7'h12, 24'h000000), fw(1, 7'h03, 24'h456789), "R5 zero multiplicand", 0);
    op(fw(0, 7'h05, 24'h314159), fw(1, 7'h33, 24'h000000), "R5 zero multiplier", 0);
    op(fw(0, 7'h00, 24'h012345), fw(0, 7'h00, 24'h200000), "R9 leading zero operand", 0);
    op(fw(0, 7'h03, 24'h000007), fw(0, 7'h01, 24'h000003), "R9 many leading zeros", 0);
    op(fw(0, 7'h00, 24'h987654), fw(0, 7'h00, 24'h999999), "R7 poke while busy", 1);
    begin
      logic [31:0] held;
      held = result;
      repeat (8) @(negedge clk);
      check(result === held, "R8 result held while idle", result, held);
    end
    op(fw(0, 7'h00, 24'h271828), fw(0, 7'h00, 24'h314159), "R3 mixed digits", 0);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R6 all results delivered", 32'(exp_q.size()), 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "R6 watchdog expired", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule